// File: doc/BRIEF.md
# Duty Cycle Limiter with Saturation Feedforward

This block sits between a digital compensator and a PWM generator. Once per switching period, flagged by a cycle-start strobe, it takes a signed duty command from the compensator and a signed error sample. It then registers a bounded, unsigned duty value for the PWM counter. Normally the command is clamped between zero and a programmable ceiling. The ceiling is set in steps of 1/64 of full scale.

A window is defined by two signed thresholds. When the error leaves this window, the block can skip the gradual loop response. An error above the window pins the duty at the ceiling, and an error below it drives the duty to zero. Each direction has its own enable. The forced value appears in the same switching period in which the excursion is seen.

A byte-wide register port holds three registers: the configuration byte and the two thresholds. Writes take one clock, and reads are combinational.

Top module: `duty_guard`

## Requirements
- R1: After reset, the configuration register reads 0xE8, the high threshold reads 0x10, the low threshold reads 0xF0 (-16), and `duty_o` is 0.
- R2: Register address 0 is configuration, address 1 is the high threshold and address 2 is the low threshold. A write with `reg_wr_i` high lands at the next clock edge. `reg_rdata_o` returns the addressed register combinationally, with thresholds sign-extended to 8 bits. Address 3 reads 0, and writes to it change no register.
- R3: Configuration bits 7:2 hold the limit code n, bit 1 enables upper forcing and bit 0 enables lower forcing. The ceiling is n·2^(DUTY_W-6) in duty units, where 2^DUTY_W is full scale. With DUTY_W = 10 this is n·16.
- R4: If no forcing applies, the duty loaded is the command clamped to the range 0 to the ceiling. A negative command gives 0.
- R5: `duty_o` changes only at the clock edge where `cyc_start_i` is high. At every other edge it holds, even if the command, the error or the configuration changes.
- R6: When the error is strictly above the high threshold and bit 1 is set, the duty loaded is the ceiling, whatever the command.
- R7: When the error is strictly below the low threshold and bit 0 is set, the duty loaded is 0, whatever the command.
- R8: An error equal to a threshold counts as inside the window. An error outside the window on a side whose enable is clear gives plain clamping.
- R9: If both forcing conditions hold at once, which needs a high threshold below the low one, upper forcing wins.
- R10: Limit code 0 caps the duty at 0, and limit code 0x3F caps it at 63·2^(DUTY_W-6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| cyc_start_i | input | 1 | Switching-period start strobe |
| cmd_i | input | CMD_W | Signed duty command from the compensator |
| err_i | input | ERR_W | Signed error sample |
| duty_o | output | DUTY_W | Bounded duty value for the PWM counter |

## Verification
The bench puts the error exactly on each threshold and one step past it. A design using non-strict compares would force at the threshold value itself, and one with off-by-one thresholds would miss the first outside value. It drives commands that are negative, inside the range and above the ceiling. A clamp that treats the command as unsigned would output a large duty for a negative command. It also sets up crossed thresholds, so that a swapped priority shows as zero instead of the ceiling. Finally it changes the command and the limit between strobes and tests codes 0 and 0x3F, which catches a duty that reloads on every clock or a ceiling shifted by the wrong amount.

// File: rtl/dgd_pkg.sv
package dgd_pkg;
   localparam int REG_W  = 8;
   localparam int CODE_W = 6;

   typedef enum logic [1:0] {
      ADDR_CFG  = 2'd0,
      ADDR_HI   = 2'd1,
      ADDR_LO   = 2'd2,
      ADDR_NONE = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              hi_en;
      logic              lo_en;
   } cfg_t;

   localparam cfg_t CFG_RST = 8'hE8;
endpackage

// File: rtl/dgd_regs.sv
module dgd_regs
   import dgd_pkg::*;
#(
   parameter int                        ERR_W  = 8,
   parameter logic signed [ERR_W-1:0]   HI_RST = 16,
   parameter logic signed [ERR_W-1:0]   LO_RST = -16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              addr,
   input  logic [REG_W-1:0]        wdata,
   output logic [REG_W-1:0]        rdata,
   output cfg_t                    cfg,
   output logic signed [ERR_W-1:0] hi_thr,
   output logic signed [ERR_W-1:0] lo_thr
);
   cfg_t                    cfg_q;
   logic signed [ERR_W-1:0] hi_q, lo_q;
   logic [REG_W-1:0]        hi_rd, lo_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
         hi_q  <= HI_RST;
         lo_q  <= LO_RST;
      end else if (wr_en) begin
         case (addr)
            ADDR_CFG: cfg_q <= cfg_t'(wdata);
            ADDR_HI:  hi_q  <= wdata[ERR_W-1:0];
            ADDR_LO:  lo_q  <= wdata[ERR_W-1:0];
            default:  ;
         endcase
      end
   end

   generate
      if (ERR_W == REG_W) begin : g_rd_full
         assign hi_rd = hi_q;
         assign lo_rd = lo_q;
      end else begin : g_rd_ext
         assign hi_rd = {{(REG_W-ERR_W){hi_q[ERR_W-1]}}, hi_q};
         assign lo_rd = {{(REG_W-ERR_W){lo_q[ERR_W-1]}}, lo_q};
      end
   endgenerate

   always_comb begin
      case (addr)
         ADDR_CFG: rdata = cfg_q;
         ADDR_HI:  rdata = hi_rd;
         ADDR_LO:  rdata = lo_rd;
         default:  rdata = '0;
      endcase
   end

   assign cfg    = cfg_q;
   assign hi_thr = hi_q;
   assign lo_thr = lo_q;

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_CFG) |=> (cfg_q == $past(wdata))); // R2
   AST_NONE_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_NONE) |=> ($stable(cfg_q) && $stable(hi_q) && $stable(lo_q))); // R2
endmodule

// File: rtl/dgd_window.sv
module dgd_window #(
   parameter int ERR_W = 8
) (
   input  logic signed [ERR_W-1:0] err,
   input  logic signed [ERR_W-1:0] hi_thr,
   input  logic signed [ERR_W-1:0] lo_thr,
   input  logic                    hi_en,
   input  logic                    lo_en,
   output logic                    force_hi,
   output logic                    force_lo
);
   logic above, below;

   assign above    = err > hi_thr;
   assign below    = err < lo_thr;
   assign force_hi = above && hi_en;
   assign force_lo = below && lo_en && !force_hi;
endmodule

// File: rtl/dgd_shape.sv
module dgd_shape
   import dgd_pkg::*;
#(
   parameter int CMD_W  = 12,
   parameter int DUTY_W = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cyc_start,
   input  logic signed [CMD_W-1:0] cmd,
   input  logic [CODE_W-1:0]       code,
   input  logic                    force_hi,
   input  logic                    force_lo,
   output logic [DUTY_W-1:0]       duty
);
   localparam int MAG_W = CMD_W - 1;

   logic [DUTY_W-1:0] lim, nxt, duty_q;
   logic [MAG_W-1:0]  mag, lim_ext;

   generate
      if (DUTY_W == CODE_W) begin : g_lim_direct
         assign lim = code;
      end else begin : g_lim_scaled
         assign lim = {code, {(DUTY_W-CODE_W){1'b0}}};
      end
   endgenerate

   assign mag     = cmd[MAG_W-1:0];
   assign lim_ext = MAG_W'(lim);

   always_comb begin
      if (force_hi)             nxt = lim;
      else if (force_lo)        nxt = '0;
      else if (cmd[CMD_W-1])    nxt = '0;
      else if (mag > lim_ext)   nxt = lim;
      else                      nxt = mag[DUTY_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         duty_q <= '0;
      else if (cyc_start) duty_q <= nxt;
   end

   assign duty = duty_q;

   AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> (duty_q <= $past(lim))); // R4
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(duty_q)); // R5
   AST_FORCE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && force_hi) |=> (duty_q == $past(lim))); // R6
   AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && force_lo) |=> (duty_q == '0)); // R7
endmodule

// File: rtl/duty_guard.sv
module duty_guard
   import dgd_pkg::*;
#(
   parameter int                      CMD_W  = 12,
   parameter int                      DUTY_W = 10,
   parameter int                      ERR_W  = 8,
   parameter logic signed [ERR_W-1:0] HI_RST = 16,
   parameter logic signed [ERR_W-1:0] LO_RST = -16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr_i,
   input  logic [1:0]              reg_addr_i,
   input  logic [REG_W-1:0]        reg_wdata_i,
   output logic [REG_W-1:0]        reg_rdata_o,
   input  logic                    cyc_start_i,
   input  logic signed [CMD_W-1:0] cmd_i,
   input  logic signed [ERR_W-1:0] err_i,
   output logic [DUTY_W-1:0]       duty_o
);
   generate
      if (DUTY_W < CODE_W) begin : g_bad_duty
         $error("DUTY_W must be at least the limit code width");
      end
      if (CMD_W <= DUTY_W) begin : g_bad_cmd
         $error("CMD_W must exceed DUTY_W");
      end
      if (ERR_W > REG_W || ERR_W < 2) begin : g_bad_err
         $error("ERR_W must lie between 2 and the register width");
      end
   endgenerate

   cfg_t                    cfg;
   logic signed [ERR_W-1:0] hi_thr, lo_thr;
   logic                    force_hi, force_lo;

   dgd_regs #(.ERR_W(ERR_W), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
      .wdata(reg_wdata_i), .rdata(reg_rdata_o), .cfg(cfg),
      .hi_thr(hi_thr), .lo_thr(lo_thr)
   );

   dgd_window #(.ERR_W(ERR_W)) u_window (
      .err(err_i), .hi_thr(hi_thr), .lo_thr(lo_thr),
      .hi_en(cfg.hi_en), .lo_en(cfg.lo_en),
      .force_hi(force_hi), .force_lo(force_lo)
   );

   dgd_shape #(.CMD_W(CMD_W), .DUTY_W(DUTY_W)) u_shape (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start_i), .cmd(cmd_i),
      .code(cfg.code), .force_hi(force_hi), .force_lo(force_lo),
      .duty(duty_o)
   );
endmodule

// File: tb/duty_guard_tb.sv
module duty_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CMD_W = 12, DUTY_W = 10, ERR_W = 8;

   logic                    clk = 0, rst_n = 0;
   logic                    reg_wr_i = 0;
   logic [1:0]              reg_addr_i = 0;
   logic [7:0]              reg_wdata_i = 0, reg_rdata_o;
   logic                    cyc_start_i = 0;
   logic signed [CMD_W-1:0] cmd_i = 0;
   logic signed [ERR_W-1:0] err_i = 0;
   logic [DUTY_W-1:0]       duty_o;

   int n_chk = 0, n_fail = 0, last_exp = 0;
   int cur_cfg = 'hE8, cur_hi = 16, cur_lo = -16;
   int exp_q[$];
   string tag_q[$];

   duty_guard u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int model(input int c, input int e);
      int lim = ((cur_cfg >> 2) & 'h3F) * 16;
      if (e > cur_hi && cur_cfg[1]) return lim;
      if (e < cur_lo && cur_cfg[0]) return 0;
      if (c < 0) return 0;
      if (c > lim) return lim;
      return c;
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr_i = 1; reg_addr_i = 2'(a); reg_wdata_i = 8'(d);
      @(negedge clk);
      reg_wr_i = 0;
      if (a == 0) cur_cfg = d & 'hFF;
      if (a == 1) cur_hi = int'($signed(8'(d)));
      if (a == 2) cur_lo = int'($signed(8'(d)));
   endtask

   task automatic rd(input int a, input int exp, input string tag);
      @(negedge clk);
      reg_addr_i = 2'(a);
      #1 chk(int'(reg_rdata_o), exp, tag);
   endtask

   task automatic cyc(input int c, input int e, input string tag);
      @(negedge clk);
      cmd_i = CMD_W'(c); err_i = ERR_W'(e); cyc_start_i = 1;
      last_exp = model(c, e);
      exp_q.push_back(last_exp);
      tag_q.push_back(tag);
      @(negedge clk);
      cyc_start_i = 0;
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         if (cyc_start_i) begin
            @(negedge clk);
            chk(int'(duty_o), exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rd(0, 'hE8, "R1 cfg reset");
      rd(1, 'h10, "R1 hi reset");
      rd(2, 'hF0, "R1 lo reset");
      chk(int'(duty_o), 0, "R1 duty reset");
      // R4 plain clamping, ceiling 58*16 = 928
      cyc(500, 0, "R4 in range");
      cyc(-20, 0, "R4 negative cmd");
      cyc(2000, 0, "R4 above ceiling");
      // R8 enables clear: plain clamp outside the window
      cyc(300, 100, "R8 hi side disabled");
      cyc(310, -100, "R8 lo side disabled");
      // R2 / R3 register access and field layout
      wr(0, 'hEB);
      rd(0, 'hEB, "R2 cfg readback");
      wr(3, 'h55);
      rd(3, 0, "R2 unmapped reads zero");
      rd(0, 'hEB, "R2 unmapped write ignored");
      // R6 / R7 / R8 forcing and boundaries
      cyc(300, 17, "R6 force ceiling");
      cyc(300, 16, "R8 at high threshold");
      cyc(300, -17, "R7 force zero");
      cyc(320, -16, "R8 at low threshold");
      cyc(-50, 17, "R6 force with negative cmd");
      cyc(2000, -17, "R7 force with large cmd");
      // R9 crossed thresholds
      wr(1, -5);
      wr(2, 5);
      rd(1, 'hFB, "R2 hi readback");
      rd(2, 'h05, "R2 lo readback");
      cyc(100, 0, "R9 upper wins");
      wr(1, 16);
      wr(2, -16);
      // R5 hold between strobes
      cyc(400, 0, "R5 load");
      @(negedge clk);
      cmd_i = 12'sd50; err_i = 8'sd100;
      wr(0, 'h00);
      repeat (3) @(negedge clk);
      chk(int'(duty_o), 400, "R5 hold without strobe");
      // R10 extreme codes, R3 scaling
      cyc(500, 0, "R10 code zero");
      wr(0, 'hFC);
      cyc(2000, 0, "R10 code 3F");
      cyc(1008, 0, "R3 exact ceiling");
      wr(0, 'h04);
      cyc(40, 0, "R3 code one");
      repeat (3) @(negedge clk);
      chk(exp_q.size(), 0, "scoreboard drained");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule